// File: doc/BRIEF.md
# I2C Slave Command and Error Handler

This block sits behind a byte-level I2C slave front end and receives one decoded access at a time. Each access carries the 7-bit device address seen on the bus, a general-call flag, a register address byte, a read/write flag and, for writes, a data byte. The block owns the device's bus address, the command register, the status register and the error register. It answers every access one cycle later with an acknowledge decision and, for reads of its own registers, the data byte.

Accepted commands leave the block as single-cycle pulses, one dedicated line per command, for the neighbouring blocks that do the work. Illegal accesses store an error code that stays until a reset. A write of a new bus address is held as a pending value. It replaces the live address only when a persist command has been accepted and a restart command follows it. Errors reported by other blocks are merged into the same error register.

Top module: `i2c_cmd_handler`

## Requirements
- R1: After the synchronous active-low reset, the device answers on address 0x50, the error register (0x02) reads 0x00, the status error bit is clear and no command line pulses.
- R2: Every access gets a response one clock later (`resp_valid_o`). `resp_ack_o` is set for reads and writes addressed to the live own address and for general-call writes. Any other access is not acknowledged and changes no state.
- R3: A write to register 0x01 on the own address with a known code gives exactly one one-cycle pulse, one clock later, on `cmd_stb_o[k]`. The mapping is: code 0x00→k0 no-op, 0x01→k1 restart, 0x02→k2 recalibrate, 0x03→k3 debug toggle, 0x05→k4 charge clear, 0x26→k5 persist, 0x27→k6 period latch, 0xAA→k7 factory restore.
- R4: A write of any other code to register 0x01 sets the error register to 0xFE and pulses no line.
- R5: On general call (`txn_gcall_i`), only codes 0x01 and 0x27 are executed. Every other code written to 0x01 sets 0xFE and pulses nothing. General-call writes to other registers are ignored.
- R6: A write to the read-only registers 0x00 (status) or 0x02 (error) sets error 0xFE.
- R7: A write to register 0x30 with a value in 0x08..0x77 becomes the pending address, which reads back at 0x30. Any other value sets 0xFE and leaves the pending address unchanged.
- R8: The pending address becomes the live address only on a restart command accepted after a persist command, with no address write in between. A restart in any other state discards the pending value, so 0x30 reads the live address again.
- R9: An accepted factory-restore command returns both live and pending address to 0x50 and clears the error register.
- R10: The error register holds its value until an accepted restart, factory restore or reset clears it. A newer error code overwrites an older one. A stored code always has bit 7 set.
- R11: The status register (0x00) reads bit 0 = `ready_i`, bit 1 = (error register not 0x00), and all other bits 0.
- R12: An external report (`ext_err_valid_i`) is stored only if its code has bit 7 set. In the same cycle, a local access error wins over it, and the report wins over a clear by restart.
- R13: A read on the own address of a register in 0xC0..0xC7 while `opt_fitted_i` is low raises `resp_nack_req_o` and is not acknowledged. With the option fitted, or outside that window, the read is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_valid_i | input | 1 | One decoded bus access this cycle |
| txn_gcall_i | input | 1 | Access arrived on the general-call address |
| txn_dev_addr_i | input | 7 | 7-bit device address from the bus |
| txn_rnw_i | input | 1 | 1 = read, 0 = write |
| txn_reg_i | input | 8 | Register address byte |
| txn_wdata_i | input | 8 | Write data byte |
| ready_i | input | 1 | Ready flag shown in status bit 0 |
| opt_fitted_i | input | 1 | Optional register window is present |
| ext_err_valid_i | input | 1 | Error report from another block |
| ext_err_code_i | input | 8 | Code of that report |
| resp_valid_o | output | 1 | Response to last cycle's access |
| resp_ack_o | output | 1 | Access acknowledged |
| resp_nack_req_o | output | 1 | Read hit an absent option; NACK requested |
| resp_rdata_o | output | 8 | Read data (0 when not acknowledged) |
| cmd_stb_o | output | 8 | One-cycle command pulses, one line per command |

## Verification
Two error writers can act in the same cycle: a local access error and an external error report. A restart clear can also coincide with an external report. The bench drives an external report in the same cycle as an illegal command write, and again in the same cycle as a restart command. It then reads register 0x02 and judges the result by the stated priority: the local code wins in the first case, and the report survives the clear in the second. Sweeps of all 256 command codes, on the own address and on general call, and of all 256 address values check strobes and error codes against expectations computed in the bench.

// File: rtl/cmdh_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types of the command/error handler.
// Assumes 8-bit register addresses and data bytes.
package cmdh_pkg;

    localparam int N_CMD = 8;

    // Position of each command's strobe line on cmd_stb_o.
    typedef enum logic [2:0] {
        CI_NOP     = 3'd0,
        CI_RESTART = 3'd1,
        CI_RECAL   = 3'd2,
        CI_DEBUG   = 3'd3,
        CI_CHARGE  = 3'd4,
        CI_PERSIST = 3'd5,
        CI_LATCH   = 3'd6,
        CI_FACTORY = 3'd7
    } cmd_idx_e;

    // Commands that general call may execute (restart, period latch).
    localparam logic [N_CMD-1:0] GC_MASK = 8'b0100_0010;

    localparam logic [7:0] REG_STATUS = 8'h00;
    localparam logic [7:0] REG_CMD    = 8'h01;
    localparam logic [7:0] REG_ERR    = 8'h02;
    localparam logic [7:0] REG_ADDR   = 8'h30;

    localparam logic [7:0] ERR_NONE    = 8'h00;
    localparam logic [7:0] ERR_BAD_ARG = 8'hFE;

    localparam int ST_READY_BIT = 0;
    localparam int ST_ERR_BIT   = 1;

    // Bus code of the command on strobe line i.
    function automatic logic [7:0] cmd_code(input int i);
        case (i)
            0:       cmd_code = 8'h00;
            1:       cmd_code = 8'h01;
            2:       cmd_code = 8'h02;
            3:       cmd_code = 8'h03;
            4:       cmd_code = 8'h05;
            5:       cmd_code = 8'h26;
            6:       cmd_code = 8'h27;
            default: cmd_code = 8'hAA;
        endcase
    endfunction

endpackage

// File: rtl/cmdh_cmd_dec.sv
`timescale 1ns/1ps
// Command decoder.
// Compares a command-register write against every known code, applies the
// general-call filter, reports an unknown/filtered code as bad, and
// registers the accepted command as a one-cycle strobe.
// Assumes at most one command write per cycle.
module cmdh_cmd_dec
    import cmdh_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmd_i,
    input  logic             gcall_i,
    input  logic [DW-1:0]    code_i,
    output logic [N_CMD-1:0] acc_o,
    output logic             bad_o,
    output logic [N_CMD-1:0] stb_o
);

    logic [N_CMD-1:0] match;
    logic [N_CMD-1:0] allow;
    logic [N_CMD-1:0] stb_q;

    // One comparator per known command code.
    generate
        for (genvar g = 0; g < N_CMD; g++) begin : g_match
            assign match[g] = (code_i == DW'(cmd_code(g)));
        end
    endgenerate

    // General call narrows the accepted set.
    always_comb begin
        allow = gcall_i ? GC_MASK : {N_CMD{1'b1}};
        acc_o = wr_cmd_i ? (match & allow) : '0;
        bad_o = wr_cmd_i && (acc_o == '0);
    end

    // Register accepted commands into one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= '0;
        else        stb_q <= acc_o;
    end

    assign stb_o = stb_q;

    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb_q)); // R3
    AST_STB_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_q != '0) |-> $past(wr_cmd_i)); // R3
    AST_GC_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        ((stb_q != '0) && $past(gcall_i)) |-> ((stb_q & ~GC_MASK) == '0)); // R5

endmodule

// File: rtl/cmdh_addr_ctl.sv
`timescale 1ns/1ps
// Device address control.
// Holds the live bus address, a pending address and an arm flag set by the
// persist command. The live address changes only on an armed restart or a
// factory restore. Also matches incoming non-general-call addresses.
// Assumes persist/restart/factory inputs are accepted-command pulses.
module cmdh_addr_ctl #(
    parameter int            AW       = 7,
    parameter int            DW       = 8,
    parameter logic [AW-1:0] DEF_ADDR = 7'h50,
    parameter logic [AW-1:0] ADDR_MIN = 7'h08,
    parameter logic [AW-1:0] ADDR_MAX = 7'h77
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] dev_addr_i,
    input  logic          gcall_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wr_val_i,
    input  logic          persist_i,
    input  logic          restart_i,
    input  logic          factory_i,
    output logic          own_hit_o,
    output logic          wr_bad_o,
    output logic [AW-1:0] pending_o
);

    localparam logic [DW-1:0] MIN_W = DW'(ADDR_MIN);
    localparam logic [DW-1:0] MAX_W = DW'(ADDR_MAX);

    logic [AW-1:0] active_q;
    logic [AW-1:0] pending_q;
    logic          armed_q;
    logic          in_range;

    // Address match and range check of a new value.
    always_comb begin
        own_hit_o = !gcall_i && (dev_addr_i == active_q);
        in_range  = (wr_val_i >= MIN_W) && (wr_val_i <= MAX_W);
        wr_bad_o  = wr_i && !in_range;
    end

    // Live/pending address and arm flag sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= DEF_ADDR;
            pending_q <= DEF_ADDR;
            armed_q   <= 1'b0;
        end else if (factory_i) begin
            active_q  <= DEF_ADDR;
            pending_q <= DEF_ADDR;
            armed_q   <= 1'b0;
        end else if (restart_i) begin
            if (armed_q) active_q  <= pending_q;
            else         pending_q <= active_q;
            armed_q <= 1'b0;
        end else if (persist_i) begin
            armed_q <= 1'b1;
        end else if (wr_i && in_range) begin
            pending_q <= wr_val_i[AW-1:0];
            armed_q   <= 1'b0;
        end
    end

    assign pending_o = pending_q;

    AST_LIVE_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q >= ADDR_MIN) && (active_q <= ADDR_MAX)); // R7
    AST_LIVE_ONLY_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && !factory_i) |=> $stable(active_q)); // R8
    AST_BAD_VALUE_KEEPS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bad_o && !restart_i && !factory_i && !persist_i) |=> $stable(pending_q)); // R7

endmodule

// File: rtl/cmdh_err_reg.sv
`timescale 1ns/1ps
// Sticky error register.
// Stores the most recent error code; a local access error beats an external
// report in the same cycle, and any report beats a clear.
// Assumes local codes always have bit 7 set.
module cmdh_err_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          loc_set_i,
    input  logic [DW-1:0] loc_code_i,
    input  logic          ext_set_i,
    input  logic [DW-1:0] ext_code_i,
    input  logic          clr_i,
    output logic [DW-1:0] err_o
);

    logic [DW-1:0] err_q;
    logic          ext_ok;

    // External reports count only with the error-class bit set.
    assign ext_ok = ext_set_i && ext_code_i[DW-1];

    // Priority update: local, then external, then clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         err_q <= '0;
        else if (loc_set_i) err_q <= loc_code_i;
        else if (ext_ok)    err_q <= ext_code_i;
        else if (clr_i)     err_q <= '0;
    end

    assign err_o = err_q;

    AST_ERR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q == '0) || err_q[DW-1]); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!loc_set_i && !ext_ok && !clr_i) |=> $stable(err_q)); // R10
    AST_LOCAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        loc_set_i |=> (err_q == $past(loc_code_i))); // R12

endmodule

// File: rtl/i2c_cmd_handler.sv
`timescale 1ns/1ps
// I2C slave command and error handler (top).
// Takes one decoded bus access per cycle, decides acknowledge, serves the
// status, command, error and address registers, dispatches commands as
// strobes and keeps the sticky error code. Responses are registered and
// appear one clock after the access.
// Assumes the front end presents at most one access per cycle.
module i2c_cmd_handler
    import cmdh_pkg::*;
#(
    parameter int            AW       = 7,
    parameter int            DW       = 8,
    parameter logic [AW-1:0] DEF_ADDR = 7'h50,
    parameter logic [AW-1:0] ADDR_MIN = 7'h08,
    parameter logic [AW-1:0] ADDR_MAX = 7'h77,
    parameter logic [DW-1:0] OPT_LO   = 8'hC0,
    parameter logic [DW-1:0] OPT_HI   = 8'hC7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txn_valid_i,
    input  logic             txn_gcall_i,
    input  logic [AW-1:0]    txn_dev_addr_i,
    input  logic             txn_rnw_i,
    input  logic [DW-1:0]    txn_reg_i,
    input  logic [DW-1:0]    txn_wdata_i,
    input  logic             ready_i,
    input  logic             opt_fitted_i,
    input  logic             ext_err_valid_i,
    input  logic [DW-1:0]    ext_err_code_i,
    output logic             resp_valid_o,
    output logic             resp_ack_o,
    output logic             resp_nack_req_o,
    output logic [DW-1:0]    resp_rdata_o,
    output logic [N_CMD-1:0] cmd_stb_o
);

    localparam logic [DW-1:0] R_STATUS = DW'(REG_STATUS);
    localparam logic [DW-1:0] R_CMD    = DW'(REG_CMD);
    localparam logic [DW-1:0] R_ERR    = DW'(REG_ERR);
    localparam logic [DW-1:0] R_ADDR   = DW'(REG_ADDR);

    logic             own_hit;
    logic             own_wr, own_rd, gc_wr;
    logic             wr_cmd, ro_bad, addr_wr, addr_bad, cmd_bad;
    logic             opt_miss, loc_err, clr_err;
    logic [N_CMD-1:0] acc;
    logic [AW-1:0]    pending;
    logic [DW-1:0]    err;
    logic [DW-1:0]    status;
    logic [DW-1:0]    rd_mux;
    logic             resp_valid_q, resp_ack_q, resp_nack_q;
    logic [DW-1:0]    resp_rdata_q;

    // Classify the current access.
    always_comb begin
        own_wr   = txn_valid_i && own_hit && !txn_rnw_i;
        own_rd   = txn_valid_i && own_hit &&  txn_rnw_i;
        gc_wr    = txn_valid_i && txn_gcall_i && !txn_rnw_i;
        wr_cmd   = (own_wr || gc_wr) && (txn_reg_i == R_CMD);
        ro_bad   = own_wr && ((txn_reg_i == R_STATUS) || (txn_reg_i == R_ERR));
        addr_wr  = own_wr && (txn_reg_i == R_ADDR);
        opt_miss = own_rd && !opt_fitted_i &&
                   (txn_reg_i >= OPT_LO) && (txn_reg_i <= OPT_HI);
        loc_err  = cmd_bad || ro_bad || addr_bad;
        clr_err  = acc[CI_RESTART] || acc[CI_FACTORY];
    end

    cmdh_cmd_dec #(.DW(DW)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cmd_i (wr_cmd),
        .gcall_i  (txn_gcall_i),
        .code_i   (txn_wdata_i),
        .acc_o    (acc),
        .bad_o    (cmd_bad),
        .stb_o    (cmd_stb_o)
    );

    cmdh_addr_ctl #(
        .AW       (AW),
        .DW       (DW),
        .DEF_ADDR (DEF_ADDR),
        .ADDR_MIN (ADDR_MIN),
        .ADDR_MAX (ADDR_MAX)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_addr_i (txn_dev_addr_i),
        .gcall_i    (txn_gcall_i),
        .wr_i       (addr_wr),
        .wr_val_i   (txn_wdata_i),
        .persist_i  (acc[CI_PERSIST]),
        .restart_i  (acc[CI_RESTART]),
        .factory_i  (acc[CI_FACTORY]),
        .own_hit_o  (own_hit),
        .wr_bad_o   (addr_bad),
        .pending_o  (pending)
    );

    cmdh_err_reg #(.DW(DW)) u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .loc_set_i  (loc_err),
        .loc_code_i (DW'(ERR_BAD_ARG)),
        .ext_set_i  (ext_err_valid_i),
        .ext_code_i (ext_err_code_i),
        .clr_i      (clr_err),
        .err_o      (err)
    );

    // Read data selection for the registers this block owns.
    always_comb begin
        status               = '0;
        status[ST_READY_BIT] = ready_i;
        status[ST_ERR_BIT]   = (err != DW'(ERR_NONE));
        case (txn_reg_i)
            R_STATUS: rd_mux = status;
            R_ERR:    rd_mux = err;
            R_ADDR:   rd_mux = DW'(pending);
            default:  rd_mux = '0;
        endcase
    end

    // Registered response to the front end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid_q <= 1'b0;
            resp_ack_q   <= 1'b0;
            resp_nack_q  <= 1'b0;
            resp_rdata_q <= '0;
        end else begin
            resp_valid_q <= txn_valid_i;
            resp_ack_q   <= ((own_wr || own_rd) && !opt_miss) || gc_wr;
            resp_nack_q  <= opt_miss;
            resp_rdata_q <= (own_rd && !opt_miss) ? rd_mux : '0;
        end
    end

    assign resp_valid_o    = resp_valid_q;
    assign resp_ack_o      = resp_ack_q;
    assign resp_nack_req_o = resp_nack_q;
    assign resp_rdata_o    = resp_rdata_q;

    AST_RESP_FOLLOWS_TXN: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_q |-> $past(txn_valid_i)); // R2
    AST_NO_ACK_WITHOUT_TXN: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_valid_i |=> (!resp_ack_q && !resp_nack_q && (cmd_stb_o == '0))); // R2
    AST_NACK_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        resp_nack_q |-> $past(txn_rnw_i && !opt_fitted_i)); // R13

endmodule

// File: tb/i2c_cmd_handler_test.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps command codes, general-call codes and address
// values, then walks the address hand-over, error priority and option NACK.
module i2c_cmd_handler_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_valid = 1'b0, txn_gcall = 1'b0, txn_rnw = 1'b0;
    logic [6:0] txn_dev = '0;
    logic [7:0] txn_reg = '0, txn_wdata = '0;
    logic       ready = 1'b0, opt_fitted = 1'b0;
    logic       ext_v = 1'b0;
    logic [7:0] ext_code = '0;
    logic       resp_valid, resp_ack, resp_nack;
    logic [7:0] resp_rdata, cmd_stb;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic       r_valid, r_ack, r_nack;
    logic [7:0] r_rdata, r_stb;

    always #2 clk = ~clk;

    i2c_cmd_handler uut (
        .clk (clk), .rst_n (rst_n),
        .txn_valid_i (txn_valid), .txn_gcall_i (txn_gcall),
        .txn_dev_addr_i (txn_dev), .txn_rnw_i (txn_rnw),
        .txn_reg_i (txn_reg), .txn_wdata_i (txn_wdata),
        .ready_i (ready), .opt_fitted_i (opt_fitted),
        .ext_err_valid_i (ext_v), .ext_err_code_i (ext_code),
        .resp_valid_o (resp_valid), .resp_ack_o (resp_ack),
        .resp_nack_req_o (resp_nack), .resp_rdata_o (resp_rdata),
        .cmd_stb_o (cmd_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One access, with an optional external report in the same cycle.
    task automatic txn_x(input logic gc, input logic [6:0] dev, input logic rnw,
                         input logic [7:0] rg, input logic [7:0] wd,
                         input logic ev, input logic [7:0] ec);
        @(negedge clk);
        txn_valid = 1'b1; txn_gcall = gc; txn_dev = dev; txn_rnw = rnw;
        txn_reg = rg; txn_wdata = wd; ext_v = ev; ext_code = ec;
        @(negedge clk);
        txn_valid = 1'b0; ext_v = 1'b0;
        r_valid = resp_valid; r_ack = resp_ack; r_nack = resp_nack;
        r_rdata = resp_rdata; r_stb = cmd_stb;
    endtask

    task automatic wr(input logic [6:0] dev, input logic [7:0] rg, input logic [7:0] wd);
        txn_x(1'b0, dev, 1'b0, rg, wd, 1'b0, 8'h00);
    endtask

    task automatic gcw(input logic [7:0] rg, input logic [7:0] wd);
        txn_x(1'b1, 7'h00, 1'b0, rg, wd, 1'b0, 8'h00);
    endtask

    task automatic rd(input logic [6:0] dev, input logic [7:0] rg);
        txn_x(1'b0, dev, 1'b1, rg, 8'h00, 1'b0, 8'h00);
    endtask

    // Expected strobe line for a code; -1 when not executed.
    function automatic int exp_line(input logic [7:0] code, input logic gc);
        int k;
        case (code)
            8'h00: k = 0; 8'h01: k = 1; 8'h02: k = 2; 8'h03: k = 3;
            8'h05: k = 4; 8'h26: k = 5; 8'h27: k = 6; 8'hAA: k = 7;
            default: k = -1;
        endcase
        if (gc && k != 1 && k != 6) k = -1;
        return k;
    endfunction

    // Watchdog: a hang counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL R2 watchdog actual hang expected completion");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] exp_err;
        repeat (3) @(negedge clk);
        chk("R1 no strobe in reset", int'(cmd_stb), 0);
        rst_n = 1'b1;

        // R1 reset state
        rd(7'h50, 8'h02);
        chk("R1 ack on default address", int'(r_ack), 1);
        chk("R1 error clear", int'(r_rdata), 0);
        chk("R1 no strobe", int'(r_stb), 0);
        ready = 1'b1;
        rd(7'h50, 8'h00);
        chk("R1 status error bit clear", int'(r_rdata), 1);
        rd(7'h51, 8'h00);
        chk("R2 foreign read not acked", int'(r_ack), 0);
        chk("R2 response valid", int'(r_valid), 1);
        wr(7'h51, 8'h01, 8'h99);
        chk("R2 foreign write no ack", int'(r_ack), 0);
        rd(7'h50, 8'h02);
        chk("R2 foreign write no error", int'(r_rdata), 0);

        // R3/R4 sweep of every code on the own address
        exp_err = 8'h00;
        for (int c = 0; c < 256; c++) begin
            int k;
            k = exp_line(8'(c), 1'b0);
            wr(7'h50, 8'h01, 8'(c));
            chk(k >= 0 ? "R3 strobe line" : "R4 no strobe on bad code",
                int'(r_stb), k >= 0 ? (1 << k) : 0);
            chk("R2 write acked", int'(r_ack), 1);
            if (k < 0) exp_err = 8'hFE;
            else if (k == 1 || k == 7) exp_err = 8'h00;
            rd(7'h50, 8'h02);
            chk("R4 error after code", int'(r_rdata), int'(exp_err));
            chk("R3 strobe one cycle", int'(r_stb), 0);
        end

        // R5 sweep of every code on general call
        for (int c = 0; c < 256; c++) begin
            int k;
            k = exp_line(8'(c), 1'b1);
            gcw(8'h01, 8'(c));
            chk("R5 general-call strobe", int'(r_stb), k >= 0 ? (1 << k) : 0);
            chk("R2 general-call write acked", int'(r_ack), 1);
            if (k < 0) exp_err = 8'hFE;
            else if (k == 1) exp_err = 8'h00;
            rd(7'h50, 8'h02);
            chk("R5 error after general call", int'(r_rdata), int'(exp_err));
        end
        wr(7'h50, 8'h01, 8'h01);
        gcw(8'h30, 8'h22);
        rd(7'h50, 8'h30);
        chk("R5 general-call address write ignored", int'(r_rdata), 8'h50);
        rd(7'h50, 8'h02);
        chk("R5 general-call register write no error", int'(r_rdata), 0);
        txn_x(1'b1, 7'h00, 1'b1, 8'h02, 8'h00, 1'b0, 8'h00);
        chk("R2 general-call read not acked", int'(r_ack), 0);

        // R6 read-only registers
        wr(7'h50, 8'h00, 8'h55);
        rd(7'h50, 8'h02);
        chk("R6 write to status", int'(r_rdata), 8'hFE);
        wr(7'h50, 8'h01, 8'h01);
        wr(7'h50, 8'h02, 8'h00);
        rd(7'h50, 8'h02);
        chk("R6 write to error", int'(r_rdata), 8'hFE);

        // R11 status mirror
        rd(7'h50, 8'h00);
        chk("R11 status ready and error", int'(r_rdata), 3);
        ready = 1'b0;
        rd(7'h50, 8'h00);
        chk("R11 status error only", int'(r_rdata), 2);
        ready = 1'b1;
        wr(7'h50, 8'h01, 8'h01);

        // R7 sweep of every address value
        begin
            logic [6:0] exp_pend;
            exp_pend = 7'h50;
            exp_err  = 8'h00;
            for (int v = 0; v < 256; v++) begin
                wr(7'h50, 8'h30, 8'(v));
                if (v >= 8 && v <= 8'h77) exp_pend = 7'(v);
                else exp_err = 8'hFE;
                rd(7'h50, 8'h30);
                chk("R7 pending readback", int'(r_rdata), int'(exp_pend));
                rd(7'h50, 8'h02);
                chk("R7 range error", int'(r_rdata), int'(exp_err));
            end
        end

        // R8 persist then restart moves to 0x77
        wr(7'h50, 8'h01, 8'h26);
        wr(7'h50, 8'h01, 8'h01);
        rd(7'h77, 8'h30);
        chk("R8 new address live", int'(r_ack), 1);
        chk("R8 new address readback", int'(r_rdata), 8'h77);
        rd(7'h50, 8'h30);
        chk("R8 old address dropped", int'(r_ack), 0);
        rd(7'h77, 8'h02);
        chk("R10 restart clears error", int'(r_rdata), 0);
        // restart without persist discards
        wr(7'h77, 8'h30, 8'h12);
        wr(7'h77, 8'h01, 8'h01);
        rd(7'h77, 8'h30);
        chk("R8 unpersisted value discarded", int'(r_rdata), 8'h77);
        rd(7'h12, 8'h30);
        chk("R8 unpersisted address not live", int'(r_ack), 0);
        // write after persist disarms
        wr(7'h77, 8'h30, 8'h12);
        wr(7'h77, 8'h01, 8'h26);
        wr(7'h77, 8'h30, 8'h13);
        wr(7'h77, 8'h01, 8'h01);
        rd(7'h77, 8'h30);
        chk("R8 write after persist disarms", int'(r_rdata), 8'h77);
        // restart on general call applies an armed value
        wr(7'h77, 8'h30, 8'h12);
        wr(7'h77, 8'h01, 8'h26);
        gcw(8'h01, 8'h01);
        rd(7'h12, 8'h30);
        chk("R8 general-call restart applies", int'(r_ack), 1);

        // R9 factory restore
        wr(7'h12, 8'h02, 8'h00);
        wr(7'h12, 8'h30, 8'h33);
        wr(7'h12, 8'h01, 8'hAA);
        chk("R9 factory strobe", int'(r_stb), 8'h80);
        rd(7'h50, 8'h30);
        chk("R9 default address back", int'(r_rdata), 8'h50);
        rd(7'h50, 8'h02);
        chk("R9 error cleared", int'(r_rdata), 0);

        // R12 external reports and same-cycle priority
        txn_x(1'b0, 7'h50, 1'b0, 8'h01, 8'h99, 1'b1, 8'hFD);
        rd(7'h50, 8'h02);
        chk("R12 local error beats report", int'(r_rdata), 8'hFE);
        txn_x(1'b0, 7'h50, 1'b0, 8'h01, 8'h01, 1'b1, 8'hFC);
        rd(7'h50, 8'h02);
        chk("R12 report beats restart clear", int'(r_rdata), 8'hFC);
        txn_x(1'b0, 7'h51, 1'b1, 8'h00, 8'h00, 1'b1, 8'h7F);
        rd(7'h50, 8'h02);
        chk("R12 report without bit 7 ignored", int'(r_rdata), 8'hFC);
        txn_x(1'b0, 7'h51, 1'b1, 8'h00, 8'h00, 1'b1, 8'hFB);
        rd(7'h50, 8'h02);
        chk("R10 newest code overwrites", int'(r_rdata), 8'hFB);
        wr(7'h50, 8'h01, 8'h01);
        rd(7'h50, 8'h00);
        chk("R11 status clear after restart", int'(r_rdata), 1);

        // R13 optional window
        opt_fitted = 1'b0;
        for (int a = 8'hBF; a <= 8'hC8; a++) begin
            bit inside_w;
            inside_w = (a >= 8'hC0 && a <= 8'hC7);
            rd(7'h50, 8'(a));
            chk("R13 nack request", int'(r_nack), int'(inside_w));
            chk("R13 ack", int'(r_ack), int'(!inside_w));
        end
        opt_fitted = 1'b1;
        rd(7'h50, 8'hC3);
        chk("R13 fitted option acked", int'(r_ack), 1);
        chk("R13 fitted option no nack", int'(r_nack), 0);

        // R1 reset again clears everything
        wr(7'h50, 8'h00, 8'h00);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(7'h50, 8'h02);
        chk("R1 reset clears error", int'(r_rdata), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule